// File: doc/BRIEF.md
# Bit-Reversed to Natural Order Frame Reorderer

This block sits after a radix-2 transform engine whose result frames of N = 2^k samples come out in bit-reversed bin order: the sample at stream position p holds frequency bin bitrev(p). The block puts each frame back into natural order, with bin 0 first and bin N-1 last. The whole frame has to be held before it can be turned around, so the block keeps a single memory of N words. It reads each location and then overwrites it in the same cycle. The address pattern flips between the plain position and its bit-reversed form on each successive frame, so only one frame buffer is needed.

Data moves over valid/ready handshakes on both sides. A first-sample marker comes with the input, and first/last markers go out with the output. In reorder mode the output runs in lockstep with the input. Frame k is emitted while frame k+1 is being accepted, and each accepted input releases one output on the next clock. A bypass input, sampled at the start of each frame, lets callers that can work with bit-reversed order (such as a forward/inverse transform pair) pass samples straight through with one register stage and no frame delay.

Top module: `fft_order_restorer`

## Requirements
- R1: In reorder mode, the sample accepted at position p of a frame is frequency bin bitrev(p), where the log2(N) position bits are mirrored. The next frame's outputs carry that frame's bins in natural order 0, 1, ..., N-1.
- R2: The first reorder frame after reset, after a bypass frame, or after a restart produces no output. Only its successor releases it.
- R3: In a reorder frame that follows a complete reorder frame, each accepted input at position q raises out_valid on the next clock, carrying bin q of the previous frame.
- R4: out_first is 1 only on the output beat of bin 0 (or, in bypass, of stream position 0). out_last is 1 only on the beat of bin N-1 (or of position N-1).
- R5: When bypass is 1 at a frame's first accepted sample, every sample of that frame leaves unchanged and in arrival order on the clock after it is accepted.
- R6: The mode is taken only at a frame's first sample. A change of bypass in the middle of a frame has no effect until the next frame starts.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0. out_data, out_first and out_last hold their values until the beat is taken.
- R8: An accepted sample with in_first = 1 while the position counter is not at 0 starts a new frame at position 0. The partly written frame and any stored frame are dropped, so that new frame emits nothing.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bypass | input | 1 | 1 = pass bit-reversed order through; sampled at frame start |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | W | Input sample, bit-reversed bin order |
| in_first | input | 1 | Marks position 0 of an input frame |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | W | Output sample |
| out_first | output | 1 | Marks bin 0 of an output frame |
| out_last | output | 1 | Marks bin N-1 of an output frame |

## Verification
The bench labels each input with a frame tag and its true bin number, so every output can be checked against the bin and frame it should carry. A wrong address flip on alternate frames would show up as bins emitted in bit-reversed order, or as data from the wrong frame. Frames that should stay silent are counted: the first frame after reset, after a bypass frame and after a restart. A design that lost track of whether the memory held a full frame would emit stale words there. Mode flips in the middle of a frame and a restart in the middle of a frame are driven on purpose, since a design that sampled bypass on every beat or ignored the restart would mix orders inside one frame. Output backpressure and input gaps are applied together to catch a design that overwrote an unread location or changed a beat while it was stalled.

// File: rtl/fro_pkg.sv
package fro_pkg;

  typedef enum logic {
    FRO_REORDER = 1'b0,
    FRO_PASS    = 1'b1
  } fro_mode_e;

  function automatic bit fro_size_ok(input int n);
    return (n >= 8) && (n <= 1024) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/fro_frame_ram.sv
module fro_frame_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Read-first single port: the old word leaves before the new one lands.
  always_ff @(posedge clk) begin
    if (en) begin
      rdata     <= mem[addr];
      mem[addr] <= wdata;
    end
  end

endmodule

// File: rtl/fro_addr_seq.sv
module fro_addr_seq
  import fro_pkg::*;
#(
  parameter int N   = 64,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          first_mark,
  input  logic          bypass_req,
  output logic [AW-1:0] ram_addr,
  output logic          pass_o,
  output logic          emit_o,
  output logic          at_first,
  output logic          at_last
);

  localparam logic [AW-1:0] LAST_POS = AW'(N - 1);

  logic [AW-1:0] pos_q, eff_pos, rev_pos;
  logic          parity_q, have_q, emit_q, resync, cur_emit;
  fro_mode_e     mode_q, cur_mode;

  // Mirror the position bits.
  for (genvar g = 0; g < AW; g++) begin : g_rev
    assign rev_pos[g] = eff_pos[AW-1-g];
  end

  always_comb begin
    eff_pos  = first_mark ? '0 : pos_q;
    resync   = first_mark && (pos_q != '0);
    at_first = (eff_pos == '0);
    at_last  = (eff_pos == LAST_POS);
    if (at_first) begin
      cur_mode = bypass_req ? FRO_PASS : FRO_REORDER;
      cur_emit = have_q && !resync && !bypass_req;
    end else begin
      cur_mode = mode_q;
      cur_emit = emit_q;
    end
    ram_addr = parity_q ? rev_pos : eff_pos;
    pass_o   = (cur_mode == FRO_PASS);
    emit_o   = cur_emit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      parity_q <= 1'b0;
      have_q   <= 1'b0;
      emit_q   <= 1'b0;
      mode_q   <= FRO_REORDER;
    end else if (accept) begin
      pos_q  <= at_last ? '0 : eff_pos + 1'b1;
      mode_q <= cur_mode;
      emit_q <= cur_emit;
      if (cur_mode == FRO_PASS) begin
        have_q <= 1'b0;
      end else if (at_last) begin
        have_q   <= 1'b1;
        parity_q <= ~parity_q;
      end else if (resync) begin
        have_q <= 1'b0;
      end
    end
  end

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    accept && at_last |=> pos_q == '0);  // R4

  AST_PATTERN_FLIP: assert property (@(posedge clk) disable iff (rst)
    accept && at_last && (cur_mode == FRO_REORDER) |=> parity_q != $past(parity_q));  // R1

  AST_PASS_SILENT_RAM: assert property (@(posedge clk) disable iff (rst)
    mode_q == FRO_PASS |-> !emit_q);  // R5

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    accept && !at_first |=> mode_q == $past(mode_q));  // R6

  AST_RESTART_SILENT: assert property (@(posedge clk) disable iff (rst)
    accept && resync |=> !emit_q);  // R8

endmodule

// File: rtl/fft_order_restorer.sv
module fft_order_restorer
  import fro_pkg::*;
#(
  parameter int N   = 64,
  parameter int W   = 16,
  localparam int AW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bypass,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_first,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_first,
  output logic         out_last
);

  initial begin
    if (!fro_size_ok(N)) $error("fft_order_restorer: N must be a power of two in 8..1024");
  end

  logic          accept, cur_pass, cur_emit, at_first, at_last, ram_en;
  logic [AW-1:0] ram_addr;
  logic [W-1:0]  ram_q, byp_q;
  logic          sel_pass_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign ram_en   = accept && !cur_pass;

  fro_addr_seq #(.N(N)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .first_mark (in_first),
    .bypass_req (bypass),
    .ram_addr   (ram_addr),
    .pass_o     (cur_pass),
    .emit_o     (cur_emit),
    .at_first   (at_first),
    .at_last    (at_last)
  );

  fro_frame_ram #(.DEPTH(N), .W(W)) ram_i (
    .clk   (clk),
    .en    (ram_en),
    .addr  (ram_addr),
    .wdata (in_data),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      sel_pass_q <= 1'b0;
      byp_q      <= '0;
    end else if (accept) begin
      out_valid  <= cur_pass || cur_emit;
      out_first  <= at_first;
      out_last   <= at_last;
      sel_pass_q <= cur_pass;
      if (cur_pass) byp_q <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_data = sel_pass_q ? byp_q : ram_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last));  // R7

  AST_MARKS_APART: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_first && out_last));  // R4

  AST_ONE_BEAT_PER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !accept && !out_valid |=> !out_valid);  // R3

endmodule

// File: tb/fft_order_restorer_tb_top.sv
module fft_order_restorer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int W   = 16;
  localparam int LG  = 4;
  localparam int ROWS = 5;

  // Stimulus/expected table: mode (1=bypass), frames, ready drop period, valid gap period, outputs expected.
  localparam int SC_BYP [ROWS] = '{0, 0, 1, 0, 0};
  localparam int SC_FRM [ROWS] = '{3, 2, 2, 2, 1};
  localparam int SC_RDY [ROWS] = '{0, 3, 0, 2, 2};
  localparam int SC_GAP [ROWS] = '{0, 4, 3, 0, 5};
  localparam int SC_EXP [ROWS] = '{32, 32, 32, 16, 16};

  logic clk = 1'b0, rst = 1'b1;
  logic bypass = 1'b0, in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_first, out_last;
  logic [W-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft_order_restorer #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .bypass(bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_first(in_first),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  int n_chk = 0, n_err = 0, cyc = 0, seg_cnt = 0;
  int rdy_period = 0, gap_period = 0;
  bit done = 0;

  // Bench model state
  bit have = 0, m_pass = 0, m_emit = 0;
  int bpos = 0;
  logic [7:0] prev_tag = '0;
  bit pend_chk = 0, pend_exp = 0;
  logic [W+1:0] exp_q [$];
  bit exp_mode_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LG-1:0] brev(input int p);
    logic [LG-1:0] v, r;
    v = LG'(p);
    for (int i = 0; i < LG; i++) r[i] = v[LG-1-i];
    return r;
  endfunction

  // Output monitor: pre-edge values at each rising edge.
  logic [W-1:0] hold_d;
  logic hold_f, hold_l;
  bit was_stalled = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (was_stalled)
        chk(out_valid && out_data == hold_d && out_first == hold_f && out_last == hold_l,
            "R7 stall hold", int'(out_data), int'(hold_d));
      was_stalled = out_valid && !out_ready;
      hold_d = out_data; hold_f = out_first; hold_l = out_last;
      if (out_valid && out_ready) begin
        seg_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected output", int'(out_data), 0);
        end else begin
          logic [W+1:0] e;
          bit md;
          e = exp_q.pop_front();
          md = exp_mode_q.pop_front();
          chk(out_data == e[W+1:2], md ? "R5 bypass data" : "R1 natural-order data",
              int'(out_data), int'(e[W+1:2]));
          chk({out_first, out_last} == e[1:0], "R4 first/last marks",
              int'({out_first, out_last}), int'(e[1:0]));
        end
      end
    end else begin
      was_stalled = 0;
    end
  end

  task automatic tick(input logic v, input logic [W-1:0] d, input logic f, input logic b,
                      input bit force_rdy, output bit acc);
    if (pend_chk) begin
      chk(out_valid == pend_exp, pend_exp ? "R3 output one clock after accept" : "R2 silent frame",
          int'(out_valid), int'(pend_exp));
      pend_chk = 0;
    end
    out_ready = force_rdy || rdy_period == 0 || (cyc % rdy_period) != 0;
    in_valid = v; in_data = d; in_first = f; bypass = b;
    #1;
    acc = v && in_ready;
    if (out_valid && !out_ready) chk(!in_ready, "R7 input blocked", int'(in_ready), 0);
    @(negedge clk);
    cyc++;
  endtask

  task automatic send_frame(input logic [7:0] tag, input bit byp, input int flip_at, input int len);
    for (int p = 0; p < len; p++) begin
      bit acc, bnow, v;
      logic [W-1:0] d;
      d = {tag, 8'(brev(p))};
      bnow = (flip_at >= 0 && p >= flip_at) ? !byp : byp;
      acc = 0;
      while (!acc) begin
        v = !(gap_period != 0 && (cyc % gap_period) == 0);
        tick(v, d, p == 0, bnow, 0, acc);
      end
      if (p == 0) begin
        bit rs;
        rs = (bpos != 0);
        if (byp) begin m_pass = 1; have = 0; end
        else begin m_pass = 0; m_emit = have && !rs; if (rs) have = 0; end
      end
      if (m_pass) begin
        exp_q.push_back({d, p == 0, p == N-1}); exp_mode_q.push_back(1);
      end else if (m_emit) begin
        exp_q.push_back({prev_tag, 8'(p), p == 0, p == N-1}); exp_mode_q.push_back(0);
      end
      pend_chk = 1;
      pend_exp = m_pass || m_emit;
      if (p == N-1 && !m_pass) begin have = 1; prev_tag = tag; end
      bpos = (p == N-1) ? 0 : p + 1;
    end
  endtask

  task automatic drain_and_count(input int exp_cnt, input string req);
    bit acc;
    for (int i = 0; i < 6; i++) tick(0, '0, 0, 0, 1, acc);
    chk(seg_cnt == exp_cnt, req, seg_cnt, exp_cnt);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    seg_cnt = 0;
  endtask

  initial begin
    logic [7:0] tag;
    tag = 8'h10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R9 reset out_valid", int'(out_valid), 0);
    chk(in_ready, "R9 reset in_ready", int'(in_ready), 1);
    @(negedge clk);

    // Table walk
    for (int r = 0; r < ROWS; r++) begin
      rdy_period = SC_RDY[r];
      gap_period = SC_GAP[r];
      for (int f = 0; f < SC_FRM[r]; f++) begin
        send_frame(tag, SC_BYP[r] != 0, -1, N);
        tag++;
      end
      rdy_period = 0; gap_period = 0;
      drain_and_count(SC_EXP[r], SC_BYP[r] != 0 ? "R5 row count" : "R1 R2 row count");
    end

    // R6: mid-frame bypass changes ignored
    send_frame(tag, 0, 5, N); tag++;
    drain_and_count(16, "R6 reorder frame kept order");
    send_frame(tag, 1, 5, N); tag++;
    drain_and_count(16, "R6 bypass frame kept passing");

    // R8: restart in the middle of a frame
    send_frame(tag, 0, -1, N); tag++;
    drain_and_count(0, "R2 first reorder after bypass");
    send_frame(tag, 0, -1, N); tag++;
    drain_and_count(16, "R3 frame released");
    send_frame(tag, 0, -1, 6); tag++;
    drain_and_count(6, "R8 partial frame outputs");
    send_frame(tag, 0, -1, N); tag++;
    drain_and_count(0, "R8 restarted frame silent");
    send_frame(tag, 0, 3, N); tag++;
    drain_and_count(16, "R8 restarted frame released");

    // Reset in service, then first frame silent
    rdy_period = 2;
    send_frame(tag, 0, -1, 5); tag++;
    rdy_period = 0;
    drain_and_count(5, "R3 before reset");
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    have = 0; bpos = 0; pend_chk = 0;
    #1;
    chk(!out_valid, "R9 reset out_valid again", int'(out_valid), 0);
    chk(in_ready, "R9 reset in_ready again", int'(in_ready), 1);
    @(negedge clk);
    send_frame(tag, 0, -1, N); tag++;
    drain_and_count(0, "R2 silent after reset");
    send_frame(tag, 0, -1, N); tag++;
    drain_and_count(16, "R1 after reset");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule